// File: doc/BRIEF.md
# Upper I/O Region Decoder with Addressable Control Latch

This block sits on the bus of an 8-bit game CPU and serves the top quarter of its address space (both top address bits high). Two mid address bits split that region into four write functions and four read functions. The write side gives a watchdog kick, a one-cycle sound trigger, a sound command register and an eight-bit bit-addressable control latch. The latch outputs drive the NMI enable, two coin counters and the screen flip line. The read side puts one of three player-control words or one of three DIP-switch banks on the read data port.

The control latch also gates the vertical-blank interrupt. Each vertical-blank pulse sets an NMI request flip-flop while the enable bit is 1. Clearing the enable bit drops any pending request and holds it low. A frame watchdog counts vertical-blank pulses since the last kick and gives a one-cycle reset pulse when the count runs out.

The CPU bus cannot stall, so every write is taken in the cycle it is presented and every read is answered combinationally in the same cycle. No valid/ready pair is used and there is no back-pressure. The sound command and trigger are plain pins: a consumer that needs flow control must sample the trigger pulse itself.

Top module: `io_ctl_decoder`

## Requirements
- R1: After reset, coin1, coin2, flip, nmi_req, snd_on and wdog_rst are 0, and snd_cmd is 0x00.
- R2: The block responds only when addr[15:14] is 2'b11. A write outside that range changes no output. rdata is 0xFF whenever rd_en is low or the address is outside that range.
- R3: A write with addr[8:7]=2'b10 stores wdata in snd_cmd, visible from the next cycle. snd_cmd holds its value otherwise.
- R4: A write with addr[8:7]=2'b01 drives snd_on high for exactly the one following cycle.
- R5: A write with addr[8:7]=2'b11 stores wdata[0] in the latch bit chosen by addr[2:0], from the next cycle. Latch bit 2 drives coin1, bit 3 drives coin2 and bit 5 drives flip.
- R6: Latch bit 0 is the NMI enable. While it is 1, a vblank pulse sets nmi_req from the next cycle, and nmi_req then stays high.
- R7: A latch write that puts 0 in bit 0 clears nmi_req from the next cycle, and vblank cannot set it again until bit 0 is 1. The value written in a cycle decides what a vblank in that same cycle does.
- R8: A read with addr[8:7]=2'b00 returns dip2, and a read with addr[8:7]=2'b10 returns dip3, in the same cycle.
- R9: A read with addr[8:7]=2'b01 uses addr[6:5] to pick a word. 00 gives {3'b111, ctl0[4:0]}, 01 gives {1'b1, ctl1[6:0]}, 10 gives {2'b11, ctl2[5:0]} and 11 gives dip1.
- R10: A read with addr[8:7]=2'b11 returns 0xFF.
- R11: A write with addr[8:7]=2'b00 restarts the watchdog. On the 16th vblank pulse with no restart, wdog_rst is high for one cycle after that pulse, and counting starts again. A restart in the same cycle as a vblank pulse wins, so that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, one cycle per write |
| vblank | input | 1 | Vertical-blank pulse, one cycle per frame |
| dip1 | input | 8 | DIP-switch bank 1 |
| dip2 | input | 8 | DIP-switch bank 2 |
| dip3 | input | 8 | DIP-switch bank 3 |
| ctl0 | input | 5 | Coin 1, coin 2, service, 1P start, 2P start (bit 0 first) |
| ctl1 | input | 7 | 1P left, right, up, down, shoot1, shoot2, then 2P shoot3 |
| ctl2 | input | 6 | 2P left, right, up, down, shoot1, shoot2 |
| rdata | output | 8 | Read data |
| nmi_req | output | 1 | Vertical-blank NMI request |
| coin1 | output | 1 | Coin counter 1 drive |
| coin2 | output | 1 | Coin counter 2 drive |
| flip | output | 1 | Screen flip |
| snd_cmd | output | 8 | Sound command byte |
| snd_on | output | 1 | Sound trigger pulse |
| wdog_rst | output | 1 | Watchdog reset pulse |

## Verification
Two pairs of functions can land on the same clock edge. A vblank pulse can meet a latch write to the NMI enable bit, and a vblank pulse can meet a watchdog restart. The bench provokes both pairs on purpose and also lets them meet at random under biased random traffic. A cycle-level model in the bench decides each case: the enable value written in that cycle gates that vblank, and a restart beats the pulse that would have been counted. nmi_req and wdog_rst are then compared on the next edge.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  typedef enum logic [1:0] {
    FN_KICK    = 2'd0,
    FN_SND_ON  = 2'd1,
    FN_SND_CMD = 2'd2,
    FN_LATCH   = 2'd3
  } io_fn_e;

  typedef enum logic [1:0] {
    RS_CTL0 = 2'd0,
    RS_CTL1 = 2'd1,
    RS_CTL2 = 2'd2,
    RS_DIP1 = 2'd3
  } rd_sub_e;

  // address field positions the decode depends on
  localparam int FN_LSB  = 7;
  localparam int SUB_LSB = 5;

  // control latch bit roles
  localparam int LB_NMI_EN = 0;
  localparam int LB_COIN1  = 2;
  localparam int LB_COIN2  = 3;
  localparam int LB_FLIP   = 5;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
  import io_dec_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  output logic          rd_hit,
  output io_fn_e        fn,
  output rd_sub_e       sub,
  output logic [LW-1:0] bit_sel,
  output logic          kick_stb,
  output logic          snd_on_stb,
  output logic          snd_cmd_stb,
  output logic          latch_stb
);
  logic hit;
  logic wr_hit;
  logic unused_addr;

  assign hit     = &addr[AW-1:AW-2];
  assign wr_hit  = hit & wr_en;
  assign rd_hit  = hit & rd_en;
  assign fn      = io_fn_e'(addr[FN_LSB+1:FN_LSB]);
  assign sub     = rd_sub_e'(addr[SUB_LSB+1:SUB_LSB]);
  assign bit_sel = addr[LW-1:0];

  assign unused_addr = ^{addr[AW-3:FN_LSB+2], addr[SUB_LSB-1:LW]};

  always_comb begin
    kick_stb    = 1'b0;
    snd_on_stb  = 1'b0;
    snd_cmd_stb = 1'b0;
    latch_stb   = 1'b0;
    if (wr_hit) begin
      unique case (fn)
        FN_KICK:    kick_stb    = 1'b1;
        FN_SND_ON:  snd_on_stb  = 1'b1;
        FN_SND_CMD: snd_cmd_stb = 1'b1;
        FN_LATCH:   latch_stb   = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/io_ctl_latch.sv
module io_ctl_latch #(
  parameter int NB     = 8,
  parameter int EN_BIT = 0,
  localparam int SW    = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [SW-1:0] sel,
  input  logic          d,
  output logic [NB-1:0] q,
  output logic          en_nxt
);
  logic [NB-1:0] q_nxt;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    assign q_nxt[i] = (wr_stb && (sel == SW'(i))) ? d : q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q_nxt[i];
    end
  end

  // enable value as it will stand after this cycle's write
  assign en_nxt = q_nxt[EN_BIT];
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
  import io_dec_pkg::*;
#(
  parameter int DW  = 8,
  parameter int C0W = 5,
  parameter int C1W = 7,
  parameter int C2W = 6
) (
  input  logic           rd_hit,
  input  io_fn_e         fn,
  input  rd_sub_e        sub,
  input  logic [DW-1:0]  dip1,
  input  logic [DW-1:0]  dip2,
  input  logic [DW-1:0]  dip3,
  input  logic [C0W-1:0] ctl0,
  input  logic [C1W-1:0] ctl1,
  input  logic [C2W-1:0] ctl2,
  output logic [DW-1:0]  rdata
);
  localparam logic [DW-1:0] IDLE = '1;

  logic [DW-1:0] ctl_word;

  always_comb begin
    unique case (sub)
      RS_CTL0: ctl_word = {{(DW-C0W){1'b1}}, ctl0};
      RS_CTL1: ctl_word = {{(DW-C1W){1'b1}}, ctl1};
      RS_CTL2: ctl_word = {{(DW-C2W){1'b1}}, ctl2};
      default: ctl_word = dip1;
    endcase
  end

  always_comb begin
    rdata = IDLE;
    if (rd_hit) begin
      unique case (fn)
        FN_KICK:    rdata = dip2;
        FN_SND_ON:  rdata = ctl_word;
        FN_SND_CMD: rdata = dip3;
        default:    rdata = IDLE;
      endcase
    end
  end
endmodule

// File: rtl/io_wdog.sv
module io_wdog #(
  parameter int FRAMES = 16,
  localparam int CW    = $clog2(FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic vblank,
  output logic wdog_rst
);
  localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wdog_rst <= 1'b0;
    end else if (kick) begin
      cnt      <= '0;
      wdog_rst <= 1'b0;
    end else if (vblank) begin
      if (cnt == LAST) begin
        cnt      <= '0;
        wdog_rst <= 1'b1;
      end else begin
        cnt      <= cnt + 1'b1;
        wdog_rst <= 1'b0;
      end
    end else begin
      wdog_rst <= 1'b0;
    end
  end
endmodule

// File: rtl/io_ctl_decoder.sv
module io_ctl_decoder
  import io_dec_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int NB        = 8,
  parameter int WD_FRAMES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          vblank,
  input  logic [DW-1:0] dip1,
  input  logic [DW-1:0] dip2,
  input  logic [DW-1:0] dip3,
  input  logic [4:0]    ctl0,
  input  logic [6:0]    ctl1,
  input  logic [5:0]    ctl2,
  output logic [DW-1:0] rdata,
  output logic          nmi_req,
  output logic          coin1,
  output logic          coin2,
  output logic          flip,
  output logic [DW-1:0] snd_cmd,
  output logic          snd_on,
  output logic          wdog_rst
);
  localparam int LW = $clog2(NB);

  logic          rd_hit;
  io_fn_e        fn;
  rd_sub_e       sub;
  logic [LW-1:0] bit_sel;
  logic          kick_stb, snd_on_stb, snd_cmd_stb, latch_stb;
  logic [NB-1:0] lat_q;
  logic          nmi_en_nxt;
  logic          unused_lat;

  io_addr_decode #(.AW(AW), .LW(LW)) u_dec (
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .rd_hit      (rd_hit),
    .fn          (fn),
    .sub         (sub),
    .bit_sel     (bit_sel),
    .kick_stb    (kick_stb),
    .snd_on_stb  (snd_on_stb),
    .snd_cmd_stb (snd_cmd_stb),
    .latch_stb   (latch_stb)
  );

  io_ctl_latch #(.NB(NB), .EN_BIT(LB_NMI_EN)) u_lat (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (latch_stb),
    .sel    (bit_sel),
    .d      (wdata[0]),
    .q      (lat_q),
    .en_nxt (nmi_en_nxt)
  );

  io_read_mux #(.DW(DW)) u_rd (
    .rd_hit (rd_hit),
    .fn     (fn),
    .sub    (sub),
    .dip1   (dip1),
    .dip2   (dip2),
    .dip3   (dip3),
    .ctl0   (ctl0),
    .ctl1   (ctl1),
    .ctl2   (ctl2),
    .rdata  (rdata)
  );

  io_wdog #(.FRAMES(WD_FRAMES)) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick_stb),
    .vblank   (vblank),
    .wdog_rst (wdog_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_cmd <= '0;
      snd_on  <= 1'b0;
      nmi_req <= 1'b0;
    end else begin
      if (snd_cmd_stb) snd_cmd <= wdata;
      snd_on  <= snd_on_stb;
      // enable as written this cycle gates this cycle's vblank
      nmi_req <= nmi_en_nxt & (nmi_req | vblank);
    end
  end

  assign coin1 = lat_q[LB_COIN1];
  assign coin2 = lat_q[LB_COIN2];
  assign flip  = lat_q[LB_FLIP];

  assign unused_lat = ^{lat_q[7:6], lat_q[4], lat_q[1], lat_q[0]};
endmodule

// File: rtl/io_ctl_decoder_chk.sv
module io_ctl_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        rd_en,
  input logic        wr_en,
  input logic        vblank,
  input logic [7:0]  rdata,
  input logic        nmi_req,
  input logic        flip,
  input logic [7:0]  snd_cmd,
  input logic        snd_on,
  input logic        wdog_rst
);
  logic hit;
  assign hit = (addr[15:14] == 2'b11);

  // R4
  snd_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && addr[8:7] == 2'b01) |=> snd_on);

  // R4
  snd_on_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit && addr[8:7] == 2'b01) |=> !snd_on);

  // R3
  snd_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit && addr[8:7] == 2'b10) |=> $stable(snd_cmd));

  // R5
  flip_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && addr[8:7] == 2'b11 && addr[2:0] == 3'd5) |=> (flip == $past(wdata[0])));

  // R7
  nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && addr[8:7] == 2'b11 && addr[2:0] == 3'd0 && !wdata[0]) |=> !nmi_req);

  // R6
  nmi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(vblank));

  // R11
  wdog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);

  // R10
  rd_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit && addr[8:7] == 2'b11) |-> (rdata == 8'hFF));

  // R2
  rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && hit) |-> (rdata == 8'hFF));
endmodule

bind io_ctl_decoder io_ctl_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (addr),
  .wdata    (wdata),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .vblank   (vblank),
  .rdata    (rdata),
  .nmi_req  (nmi_req),
  .flip     (flip),
  .snd_cmd  (snd_cmd),
  .snd_on   (snd_on),
  .wdog_rst (wdog_rst)
);

// File: tb/tb_io_ctl_decoder.sv
`timescale 1ns/1ps
module tb_io_ctl_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en, wr_en, vblank;
  logic [7:0]  dip1, dip2, dip3;
  logic [4:0]  ctl0;
  logic [6:0]  ctl1;
  logic [5:0]  ctl2;
  logic [7:0]  rdata;
  logic        nmi_req, coin1, coin2, flip, snd_on, wdog_rst;
  logic [7:0]  snd_cmd;

  always #2 clk = ~clk;

  io_ctl_decoder dut (.*);

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [7:0] m_lat;
  logic [7:0] m_cmd;
  logic       m_son, m_nmi, m_wd;
  int         m_wcnt;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    if (!rd_en || addr[15:14] != 2'b11) return 8'hFF;
    case (addr[8:7])
      2'b00: return dip2;
      2'b10: return dip3;
      2'b11: return 8'hFF;
      default: case (addr[6:5])
        2'b00: return {3'b111, ctl0};
        2'b01: return {1'b1, ctl1};
        2'b10: return {2'b11, ctl2};
        default: return dip1;
      endcase
    endcase
  endfunction

  task automatic model_reset();
    m_lat = 8'h00; m_cmd = 8'h00; m_son = 1'b0; m_nmi = 1'b0;
    m_wd = 1'b0; m_wcnt = 0;
  endtask

  task automatic model_step();
    logic       w;
    logic [7:0] nl;
    w = wr_en && (addr[15:14] == 2'b11);
    m_son = w && addr[8:7] == 2'b01;
    if (w && addr[8:7] == 2'b10) m_cmd = wdata;
    nl = m_lat;
    if (w && addr[8:7] == 2'b11) nl[addr[2:0]] = wdata[0];
    m_nmi = nl[0] && (m_nmi || vblank);
    m_lat = nl;
    if (w && addr[8:7] == 2'b00) begin
      m_wcnt = 0; m_wd = 1'b0;
    end else if (vblank) begin
      if (m_wcnt == 15) begin m_wcnt = 0; m_wd = 1'b1; end
      else begin m_wcnt++; m_wd = 1'b0; end
    end else m_wd = 1'b0;
  endtask

  task automatic check_regs();
    chk("R5 coin1", {7'd0, coin1}, {7'd0, m_lat[2]});
    chk("R5 coin2", {7'd0, coin2}, {7'd0, m_lat[3]});
    chk("R5 flip", {7'd0, flip}, {7'd0, m_lat[5]});
    chk("R3 snd_cmd", snd_cmd, m_cmd);
    chk("R4 snd_on", {7'd0, snd_on}, {7'd0, m_son});
    chk("R6/R7 nmi_req", {7'd0, nmi_req}, {7'd0, m_nmi});
    chk("R11 wdog_rst", {7'd0, wdog_rst}, {7'd0, m_wd});
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0; vblank = 1'b0;
  endtask

  // inputs are set just after a falling edge; this samples and advances
  task automatic tick();
    #1;
    chk("R8/R9/R10 rdata", rdata, exp_rd());
    model_step();
    @(negedge clk);
    check_regs();
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d, logic vb);
    addr = a; wdata = d; wr_en = 1'b1; vblank = vb;
    tick();
    idle();
  endtask

  task automatic do_rd(logic [15:0] a, string tag, logic [7:0] exp);
    addr = a; rd_en = 1'b1;
    #1;
    chk(tag, rdata, exp);
    model_step();
    @(negedge clk);
    check_regs();
    idle();
  endtask

  task automatic pulse_vb();
    vblank = 1'b1; tick();
    idle(); tick();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; addr = 16'h0000; wdata = 8'h00; idle();
    dip1 = 8'hA5; dip2 = 8'h3C; dip3 = 8'h96;
    ctl0 = 5'h0A; ctl1 = 7'h55; ctl2 = 6'h2B;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset coin1", {7'd0, coin1}, 8'd0);
    chk("R1 reset flip", {7'd0, flip}, 8'd0);
    chk("R1 reset nmi_req", {7'd0, nmi_req}, 8'd0);
    chk("R1 reset snd_cmd", snd_cmd, 8'd0);
    chk("R1 reset snd_on/wdog", {6'd0, snd_on, wdog_rst}, 8'd0);
    chk("R2 rdata idle", rdata, 8'hFF);

    // R8 R9 R10 directed read map
    do_rd(16'hC000, "R8 dip2", 8'h3C);
    do_rd(16'hC100, "R8 dip3", 8'h96);
    do_rd(16'hC080, "R9 ctl0", 8'hEA);
    do_rd(16'hC0A0, "R9 ctl1", 8'hD5);
    do_rd(16'hC0C0, "R9 ctl2", 8'hEB);
    do_rd(16'hC0E0, "R9 dip1", 8'hA5);
    do_rd(16'hC180, "R10 unused", 8'hFF);
    do_rd(16'h4000, "R2 out of range read", 8'hFF);

    // R3 R4 R5 directed writes
    do_wr(16'hC100, 8'h5E, 1'b0);
    chk("R3 snd_cmd stored", snd_cmd, 8'h5E);
    do_wr(16'hC080, 8'h00, 1'b0);
    chk("R4 snd_on high", {7'd0, snd_on}, 8'd1);
    tick();
    chk("R4 snd_on one cycle", {7'd0, snd_on}, 8'd0);
    do_wr(16'hC185, 8'h01, 1'b0);
    chk("R5 flip set", {7'd0, flip}, 8'd1);
    do_wr(16'hC182, 8'hFF, 1'b0);
    chk("R5 coin1 set", {7'd0, coin1}, 8'd1);
    do_wr(16'h8185, 8'h00, 1'b0);
    chk("R2 out of range write ignored", {7'd0, flip}, 8'd1);
    do_wr(16'h4100, 8'h77, 1'b0);
    chk("R2 out of range cmd ignored", snd_cmd, 8'h5E);

    // R6 R7 NMI gating, including same-cycle vblank
    pulse_vb();
    chk("R6 disabled vblank ignored", {7'd0, nmi_req}, 8'd0);
    do_wr(16'hC180, 8'h01, 1'b0);
    pulse_vb();
    chk("R6 nmi set", {7'd0, nmi_req}, 8'd1);
    do_wr(16'hC180, 8'h00, 1'b1);
    chk("R7 clear beats vblank", {7'd0, nmi_req}, 8'd0);
    pulse_vb();
    chk("R7 stays cleared", {7'd0, nmi_req}, 8'd0);
    do_wr(16'hC180, 8'h01, 1'b1);
    chk("R7 enable with vblank sets", {7'd0, nmi_req}, 8'd1);

    // R11 watchdog expiry and kick racing a vblank
    do_wr(16'hC000, 8'h00, 1'b0);
    for (int i = 0; i < 15; i++) pulse_vb();
    chk("R11 no fire at 15", {7'd0, wdog_rst}, 8'd0);
    vblank = 1'b1; tick(); idle();
    chk("R11 fire at 16", {7'd0, wdog_rst}, 8'd1);
    tick();
    chk("R11 single pulse", {7'd0, wdog_rst}, 8'd0);
    for (int i = 0; i < 15; i++) pulse_vb();
    do_wr(16'hC000, 8'h00, 1'b1);
    chk("R11 kick beats vblank", {7'd0, wdog_rst}, 8'd0);
    for (int i = 0; i < 15; i++) pulse_vb();
    chk("R11 restarted count", {7'd0, wdog_rst}, 8'd0);
    vblank = 1'b1; tick(); idle();
    chk("R11 fire after restart", {7'd0, wdog_rst}, 8'd1);

    // biased random traffic
    for (int n = 0; n < 4000; n++) begin
      addr  = 16'($urandom);
      if ($urandom % 4 != 0) addr[15:14] = 2'b11;
      if (addr[8:7] == 2'b00 && $urandom % 4 != 0) addr[8:7] = 2'($urandom % 3 + 1);
      wdata  = 8'($urandom);
      wr_en  = ($urandom % 3 == 0);
      rd_en  = ($urandom % 2 == 0);
      vblank = ($urandom % 5 == 0);
      if ($urandom % 16 == 0) begin
        dip1 = 8'($urandom); dip2 = 8'($urandom); dip3 = 8'($urandom);
        ctl0 = 5'($urandom); ctl1 = 7'($urandom); ctl2 = 6'($urandom);
      end
      tick();
    end
    idle();
    summary();
  end
endmodule